// File: doc/BRIEF.md
# Ring-Buffer DMA Address Sequencer

This block produces the word addresses for one direction of a bus-master DMA channel. Software sets a start address, an inclusive end address and an interrupt address. A frame-sync strobe from a serial port asks for one 32-bit word. For each accepted strobe the block raises a memory request that carries the current pointer and holds it until the memory side acknowledges it. On the acknowledge the pointer moves on by one word. There is no transfer counter. The buffer is bounded only by the end address: a buffer of n bytes at X ends at X + n − 4.

A mode input selects the behaviour at the end of the buffer. In wrap mode the pointer returns to the start and keeps running with no software action. In one-shot mode the channel halts on the last word and waits for a restart command. Two single-cycle events feed a separate interrupt block: one when the word at the interrupt address completes, and one when the end word completes. The current pointer is visible at all times. A sticky overrun flag records frame syncs that were dropped because the previous access was still outstanding.

Top module: `dma_ring_addr_seq`

## Requirements
- R1: The two low bits of the start, end and interrupt addresses are ignored (treated as zero), and `mem_addr` bits [1:0] are always zero while `mem_req` is high.
- R2: One clock after `cfg_enable` rises, `cur_addr` equals the aligned start address, `chan_halted` is 0 and `overrun` is 0.
- R3: A frame sync accepted while the channel is enabled and idle raises `mem_req` on the next clock with `mem_addr` equal to `cur_addr`. The cycle after `mem_ack` is sampled high, `mem_req` is low and `cur_addr` has advanced by 4.
- R4: In wrap mode (`cfg_oneshot` = 0), completing the word at the end address reloads `cur_addr` with the start address and pulses `evt_end` for one cycle.
- R5: In one-shot mode (`cfg_oneshot` = 1), completing the end word sets `chan_halted`, leaves `cur_addr` at the end address and pulses `evt_end`. While halted, frame syncs raise no request.
- R6: In one-shot mode, with no request outstanding, `cmd_restart` reloads `cur_addr` with the start address and clears `chan_halted`. In wrap mode `cmd_restart` leaves `cur_addr` unchanged.
- R7: `evt_irq_hit` pulses for exactly one cycle, the cycle after the acknowledge of the word whose address equals the aligned interrupt address.
- R8: While `cfg_enable` is 0, frame syncs raise no request, any outstanding request is withdrawn on the next clock, and `cur_addr` holds its value.
- R9: A frame sync that arrives while a request is outstanding, including in the cycle of its acknowledge, is dropped and sets the sticky `overrun` flag. The next rise of `cfg_enable` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_addr | input | 32 | First word address of the buffer |
| cfg_end_addr | input | 32 | Last word address of the buffer (inclusive) |
| cfg_irq_addr | input | 32 | Word address that triggers the interrupt-address event |
| cfg_oneshot | input | 1 | 0 = wrap mode, 1 = one-shot mode |
| cfg_enable | input | 1 | Channel run enable |
| cmd_restart | input | 1 | Restart pulse, used only in one-shot mode |
| fsync | input | 1 | Frame-sync strobe; each accepted strobe asks for one word |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_addr | output | 32 | Word address of the outstanding access |
| mem_ack | input | 1 | Memory access acknowledge |
| cur_addr | output | 32 | Current pointer: address of the next word |
| chan_halted | output | 1 | One-shot channel has stopped at the end address |
| evt_irq_hit | output | 1 | One-cycle pulse: interrupt-address word completed |
| evt_end | output | 1 | One-cycle pulse: end word completed (wrap or halt) |
| overrun | output | 1 | Sticky flag: a frame sync was dropped |

## Verification
A corrupted pointer shows up at `mem_addr` on the very next request and at `cur_addr` one cycle after any acknowledge. For that reason every word address is compared against a queue of expected addresses, and the pointer is checked after each acknowledge. A wrong end or interrupt comparison shows up at the end of the buffer as a missing or misplaced `evt_end` or `evt_irq_hit` pulse, or as a failure to wrap or halt. Each buffer is therefore walked across its end at least once in both modes. A wrong halt or enable state shows up within one cycle as a request that should not appear, or as one that is missing.

// File: rtl/dma_seq_pkg.sv
// Package: shared types and constants for the ring-buffer DMA address sequencer.
// Assumes every transfer moves one 32-bit word.
package dma_seq_pkg;

    // Run mode selected by the mode input
    typedef enum logic {
        MODE_WRAP    = 1'b0,
        MODE_ONESHOT = 1'b1
    } run_mode_e;

    // Bytes moved per frame sync
    localparam int WORD_BYTES = 4;
    // Low address bits that must be zero for word alignment
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);

endpackage

// File: rtl/dma_addr_align.sv
// Module: dma_addr_align
// Forces word alignment on a set of programmed addresses by clearing their
// low alignment bits. Pure combinational logic.
// Assumes N_ADDR >= 1 and ADDR_W > ALIGN_BITS.
module dma_addr_align
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_ADDR = 3
) (
    input  logic [N_ADDR-1:0][ADDR_W-1:0] raw_addr,
    output logic [N_ADDR-1:0][ADDR_W-1:0] word_addr
);

    localparam int HI_W = ADDR_W - ALIGN_BITS;

    // One clearing stage for each programmed address
    for (genvar gi = 0; gi < N_ADDR; gi++) begin : g_align
        assign word_addr[gi] = {raw_addr[gi][ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

        // Every aligned output has zero low bits
        always_comb begin
            AST_ALIGN_LOW_ZERO: assert (word_addr[gi][ALIGN_BITS-1:0] == '0); // R1
        end
    end

    // Upper part passes through unchanged
    for (genvar gj = 0; gj < N_ADDR; gj++) begin : g_chk_hi
        always_comb begin
            AST_ALIGN_HI_KEPT: assert (word_addr[gj][ADDR_W-1:ALIGN_BITS] == raw_addr[gj][ADDR_W-1:ALIGN_BITS]); // R1
        end
    end

    localparam int UNUSED_HI = HI_W;

endmodule

// File: rtl/dma_ptr_unit.sv
// Module: dma_ptr_unit
// Holds the current-address pointer and the one-shot halt state.
// - Loads the start address on a rising enable.
// - Advances by one word on each completed transfer.
// - At the end word it reloads the start (wrap mode) or halts (one-shot mode).
// - A restart reloads the start in one-shot mode only.
// Assumes the start and end inputs are already word aligned.
module dma_ptr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              oneshot,
    input  logic              restart,
    input  logic              busy,
    input  logic              done,
    input  logic              at_end,
    input  logic [ADDR_W-1:0] start_al,
    output logic [ADDR_W-1:0] ptr,
    output logic              halted,
    output logic              start_pulse
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic en_q;

    // Keep last cycle's enable so its rising edge can be detected
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    assign start_pulse = enable & ~en_q;

    // Pointer and halt state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            halted <= 1'b0;
        end else if (start_pulse) begin
            ptr    <= start_al;
            halted <= 1'b0;
        end else if (enable) begin
            if (done) begin
                if (at_end) begin
                    if (oneshot) halted <= 1'b1;
                    else         ptr    <= start_al;
                end else begin
                    ptr <= ptr + STEP;
                end
            end else if (restart && oneshot && !busy) begin
                ptr    <= start_al;
                halted <= 1'b0;
            end
        end
    end

    // Enable rise loads the start and clears the halt
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (ptr == $past(start_al)) && !halted); // R2

    // A completed non-end word advances the pointer by one word
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !at_end && enable && !start_pulse) |=> ptr == $past(ptr) + STEP); // R3

    // Wrap mode reloads the start after the end word
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && at_end && !oneshot && enable && !start_pulse) |=> ptr == $past(start_al)); // R4

    // One-shot mode halts after the end word and keeps the pointer
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && at_end && oneshot && enable && !start_pulse) |=> halted && $stable(ptr)); // R5

    // A disabled channel never moves its pointer
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(ptr)); // R8

endmodule

// File: rtl/dma_req_ctrl.sv
// Module: dma_req_ctrl
// Request/acknowledge handshake toward memory and overrun detection.
// A frame sync is accepted only when the channel is enabled, not halted,
// not in its first enabled cycle, and has no request outstanding.
// A frame sync that arrives while a request is outstanding is dropped and
// sets the sticky overrun flag.
// Assumes mem_ack is meaningful only while the request is high.
module dma_req_ctrl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              halted,
    input  logic              start_pulse,
    input  logic              fsync,
    input  logic              ack,
    input  logic [ADDR_W-1:0] ptr,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              overrun
);

    logic accept;
    logic drop;

    assign done   = req & ack;
    assign accept = enable & ~start_pulse & ~halted & fsync & ~req;
    assign drop   = enable & ~halted & fsync & req;

    // Raise, hold and retire the memory request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            addr <= '0;
        end else if (!enable) begin
            req <= 1'b0;
        end else if (done) begin
            req <= 1'b0;
        end else if (accept) begin
            req  <= 1'b1;
            addr <= ptr;
        end
    end

    // Sticky overrun flag, cleared when the channel starts
    always_ff @(posedge clk) begin
        if (!rst_n)           overrun <= 1'b0;
        else if (start_pulse) overrun <= 1'b0;
        else if (drop)        overrun <= 1'b1;
    end

    // An unacknowledged request holds with a stable address
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && enable) |=> req && $stable(addr)); // R3

    // An accepted frame sync issues the pointer value
    AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> req && (addr == $past(ptr))); // R3

    // Disable withdraws any request
    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !req); // R8

    // A halted channel raises no new request
    AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !req) |=> !req); // R5

    // A dropped frame sync always leaves overrun set
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !start_pulse) |=> overrun); // R9

endmodule

// File: rtl/dma_evt_gen.sv
// Module: dma_evt_gen
// Compares the address of the word that just completed against the aligned
// end and interrupt addresses. Gives a combinational end hit to the pointer
// unit and registered one-cycle event pulses to the interrupt block.
// Assumes done is high for at most one cycle per transfer.
module dma_evt_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [ADDR_W-1:0] end_al,
    input  logic [ADDR_W-1:0] irq_al,
    output logic              at_end,
    output logic              evt_end,
    output logic              evt_irq
);

    assign at_end = (xfer_addr == end_al);

    // Register the event pulses one cycle after completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_end <= 1'b0;
            evt_irq <= 1'b0;
        end else begin
            evt_end <= done & at_end;
            evt_irq <= done & (xfer_addr == irq_al);
        end
    end

    // Events are single-cycle pulses
    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |=> !evt_end); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |=> !evt_irq); // R7

    // An event follows only a completed transfer
    AST_EVT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> !evt_end && !evt_irq); // R7

endmodule

// File: rtl/dma_ring_addr_seq.sv
// Module: dma_ring_addr_seq (top)
// Address sequencer for one direction of a bus-master DMA channel with a
// ring buffer bounded by an inclusive end address.
// - Each accepted frame sync moves one 32-bit word over a req/ack handshake.
// - Wrap mode runs around the buffer without software action.
// - One-shot mode halts at the end and waits for a restart.
// Assumes the configuration is stable while the channel is enabled.
module dma_ring_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_end_addr,
    input  logic [ADDR_W-1:0] cfg_irq_addr,
    input  logic              cfg_oneshot,
    input  logic              cfg_enable,
    input  logic              cmd_restart,
    input  logic              fsync,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              chan_halted,
    output logic              evt_irq_hit,
    output logic              evt_end,
    output logic              overrun
);

    localparam int N_CFG = 3;

    logic [N_CFG-1:0][ADDR_W-1:0] raw_cfg;
    logic [N_CFG-1:0][ADDR_W-1:0] al_cfg;
    logic oneshot;
    logic start_pulse;
    logic done;
    logic at_end;

    assign raw_cfg[0] = cfg_start_addr;
    assign raw_cfg[1] = cfg_end_addr;
    assign raw_cfg[2] = cfg_irq_addr;
    assign oneshot    = (run_mode_e'(cfg_oneshot) == MODE_ONESHOT);

    dma_addr_align #(.ADDR_W(ADDR_W), .N_ADDR(N_CFG)) u_align (
        .raw_addr  (raw_cfg),
        .word_addr (al_cfg)
    );

    dma_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .oneshot     (oneshot),
        .restart     (cmd_restart),
        .busy        (mem_req),
        .done        (done),
        .at_end      (at_end),
        .start_al    (al_cfg[0]),
        .ptr         (cur_addr),
        .halted      (chan_halted),
        .start_pulse (start_pulse)
    );

    dma_req_ctrl #(.ADDR_W(ADDR_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .halted      (chan_halted),
        .start_pulse (start_pulse),
        .fsync       (fsync),
        .ack         (mem_ack),
        .ptr         (cur_addr),
        .req         (mem_req),
        .addr        (mem_addr),
        .done        (done),
        .overrun     (overrun)
    );

    dma_evt_gen #(.ADDR_W(ADDR_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .xfer_addr (mem_addr),
        .end_al    (al_cfg[1]),
        .irq_al    (al_cfg[2]),
        .at_end    (at_end),
        .evt_end   (evt_end),
        .evt_irq   (evt_irq_hit)
    );

    // Request addresses are always word aligned
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[ALIGN_BITS-1:0] == '0); // R1

    // Restart has no effect on the pointer in wrap mode
    AST_WRAP_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_restart && !oneshot && cfg_enable && !start_pulse && !done) |=> $stable(cur_addr)); // R6

endmodule

// File: tb/dma_ring_addr_seq_test.sv
module dma_ring_addr_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start_addr = '0, cfg_end_addr = '0, cfg_irq_addr = '0;
    logic        cfg_oneshot = 1'b0, cfg_enable = 1'b0, cmd_restart = 1'b0;
    logic        fsync = 1'b0, mem_ack = 1'b0;
    logic        mem_req, chan_halted, evt_irq_hit, evt_end, overrun;
    logic [31:0] mem_addr, cur_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    logic        req_seen = 1'b0;
    bit          done_flag = 1'b0;

    always #10 clk = ~clk;

    dma_ring_addr_seq uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
        .cfg_irq_addr(cfg_irq_addr), .cfg_oneshot(cfg_oneshot),
        .cfg_enable(cfg_enable), .cmd_restart(cmd_restart), .fsync(fsync),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .cur_addr(cur_addr), .chan_halted(chan_halted),
        .evt_irq_hit(evt_irq_hit), .evt_end(evt_end), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected address for each new request
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && !req_seen) begin
                if (exp_q.size() == 0) check("R3 unexpected request", mem_addr, 32'hFFFF_FFFF);
                else                   check("R3 request address", mem_addr, exp_q.pop_front());
            end
            req_seen = mem_req;
        end
    end

    // Driver: one full word transfer with the expected results afterwards
    task automatic xfer(input logic [31:0] addr, input logic e_irq, input logic e_end,
                        input logic [31:0] ptr_after, input string tag);
        @(negedge clk); fsync = 1'b1; exp_q.push_back(addr);
        @(negedge clk); fsync = 1'b0;
        check({tag, " req up"}, {31'd0, mem_req}, 32'd1);
        mem_ack = 1'b1;
        @(negedge clk); mem_ack = 1'b0;
        check({tag, " req down"}, {31'd0, mem_req}, 32'd0);
        check({tag, " evt_irq_hit R7"}, {31'd0, evt_irq_hit}, {31'd0, e_irq});
        check({tag, " evt_end"}, {31'd0, evt_end}, {31'd0, e_end});
        check({tag, " cur_addr"}, cur_addr, ptr_after);
    endtask

    task automatic pulse_fsync_no_req(input string tag);
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        check({tag, " no request"}, {31'd0, mem_req}, 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: the low bits are set on purpose; they must be ignored
        cfg_start_addr = 32'h0000_1002;
        cfg_end_addr   = 32'h0000_100F;
        cfg_irq_addr   = 32'h0000_1005;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset mem_req", {31'd0, mem_req}, 32'd0);
        check("reset cur_addr", cur_addr, 32'd0);
        check("reset overrun", {31'd0, overrun}, 32'd0);
        check("reset events", {30'd0, evt_end, evt_irq_hit}, 32'd0);

        // R2 and R1: enable loads the aligned start
        cfg_enable = 1'b1;
        @(negedge clk);
        check("R2 start load R1", cur_addr, 32'h1000);
        check("R2 halted clear", {31'd0, chan_halted}, 32'd0);

        // R3, R7 and R4 in wrap mode
        xfer(32'h1000, 1'b0, 1'b0, 32'h1004, "R3 w0");
        xfer(32'h1004, 1'b1, 1'b0, 32'h1008, "R7 w1");
        xfer(32'h1008, 1'b0, 1'b0, 32'h100C, "R3 w2");
        xfer(32'h100C, 1'b0, 1'b1, 32'h1000, "R4 wrap");
        xfer(32'h1000, 1'b0, 1'b0, 32'h1004, "R4 after wrap");

        // R6: restart is ignored in wrap mode
        @(negedge clk); cmd_restart = 1'b1;
        @(negedge clk); cmd_restart = 1'b0;
        check("R6 wrap restart ignored", cur_addr, 32'h1004);

        // R9: a second frame sync while a request is outstanding
        @(negedge clk); fsync = 1'b1; exp_q.push_back(32'h1004);
        @(negedge clk);
        @(negedge clk); fsync = 1'b0;
        check("R9 overrun set", {31'd0, overrun}, 32'd1);
        mem_ack = 1'b1;
        @(negedge clk); mem_ack = 1'b0;
        check("R9 dropped sync did not advance", cur_addr, 32'h1008);
        check("R9 evt_irq on ack", {31'd0, evt_irq_hit}, 32'd1);
        @(negedge clk);
        check("R9 overrun sticky", {31'd0, overrun}, 32'd1);

        // R8: disabled channel ignores frame syncs
        cfg_enable = 1'b0;
        @(negedge clk);
        pulse_fsync_no_req("R8 disabled");
        pulse_fsync_no_req("R8 disabled again");
        check("R8 pointer held", cur_addr, 32'h1008);

        // R8: disable withdraws an outstanding request
        cfg_enable = 1'b1;
        @(negedge clk);
        check("R2 reload", cur_addr, 32'h1000);
        check("R9 overrun cleared by enable", {31'd0, overrun}, 32'd0);
        @(negedge clk); fsync = 1'b1; exp_q.push_back(32'h1000);
        @(negedge clk); fsync = 1'b0; cfg_enable = 1'b0;
        @(negedge clk);
        check("R8 request withdrawn", {31'd0, mem_req}, 32'd0);
        check("R8 pointer unmoved", cur_addr, 32'h1000);

        // R5: one-shot run to the end
        cfg_oneshot = 1'b1;
        @(negedge clk); cfg_enable = 1'b1;
        @(negedge clk);
        check("R2 one-shot start", cur_addr, 32'h1000);
        xfer(32'h1000, 1'b0, 1'b0, 32'h1004, "R5 o0");
        xfer(32'h1004, 1'b1, 1'b0, 32'h1008, "R7 o1");
        xfer(32'h1008, 1'b0, 1'b0, 32'h100C, "R5 o2");
        xfer(32'h100C, 1'b0, 1'b1, 32'h100C, "R5 end");
        check("R5 halted", {31'd0, chan_halted}, 32'd1);
        pulse_fsync_no_req("R5 halted");
        check("R5 no overrun while halted", {31'd0, overrun}, 32'd0);
        check("R5 pointer held at end", cur_addr, 32'h100C);

        // R6: restart in one-shot mode
        @(negedge clk); cmd_restart = 1'b1;
        @(negedge clk); cmd_restart = 1'b0;
        check("R6 restart reload", cur_addr, 32'h1000);
        check("R6 halt cleared", {31'd0, chan_halted}, 32'd0);
        xfer(32'h1000, 1'b0, 1'b0, 32'h1004, "R6 resumed");

        repeat (2) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 32'd0);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule